// File: doc/BRIEF.md
# DDR Mode-Register Sequencer and Read-Data Window Predictor

This block sits on the controller side of a DDR SDRAM interface. It takes mode-set requests on a valid/ready channel and turns each legal request into a mode-register load on a registered command/address bus. Between consecutive loads it drives NOP cycles. A request that asks for a DLL reset is expanded into two loads: first the DLL-reset load, then a normal-operation load carrying the same low-order settings. The block checks every request against the small set of legal bit patterns. It refuses any request containing a reserved or test-mode pattern, an unsupported latency code or an unsupported burst code, and raises a one-cycle error pulse instead of driving that request.

Once a normal-operation load has been issued, the block holds the programmed CAS latency (2 or 2.5 clocks) and the burst length. For every READ strobe it then predicts the clock edges that carry read data. Two outputs mark the beats: one for rising-edge beats and one for falling-edge beats. Downstream capture logic uses them to open its sampling window on the right full or half clock edge. Each READ travels down its own stage of a shift register, so reads that are back-to-back or overlapping are predicted independently and their windows are merged.

Back-pressure on the request channel works as follows. `req_ready` is high only while no load sequence is in progress. A requester holds `req_valid` and the request fields steady until a cycle in which both signals are high. Every accepted request completes in one of two ways: it is issued as a load, or it is refused with `req_err`.

Top module: `ddr_mrs_rdlat`

## Requirements
- R1: A request accepted on a clock edge puts a load on the bus (`cmd_load` high) in the following cycle. The address bits are placed as follows: bits 12:7 carry the upper pattern, bits 6:4 the latency code, bit 3 the burst type and bits 2:0 the burst-length code.
- R2: Only two upper patterns are legal. All-zero selects normal operation. A pattern with only bit 8 set (request field value 6'b000010) selects a DLL reset. Any other upper pattern is refused.
- R3: An accepted DLL-reset request is followed automatically by a normal-operation load. This load has bits 12:7 at zero, keeps the same bits 6:0, and appears exactly three cycles after the DLL-reset load. No new request is accepted in between.
- R4: A refused request raises `req_err` for exactly one cycle, starting in the cycle after acceptance. It drives no load and leaves `mode_ready` and `lat_half` unchanged.
- R5: Two loads are separated by at least `GAP_CYC` (default 2) NOP cycles, during which `cmd_load` is low and `cmd_addr` is zero. `req_ready` is low in the first cycle after a load.
- R6: The latency code 3'b010 means 2 clocks and 3'b110 means 2.5 clocks. All other latency codes are refused. The code for 2 clocks is also refused when `CLK_MHZ` exceeds `CL2_MAX_MHZ`.
- R7: The burst-length codes 3'b001, 3'b010 and 3'b011 mean 2, 4 and 8 beats. Code 3'b011 is accepted only if `MAX_BURST` is at least 8. All other burst codes are refused.
- R8: Issuing a normal-operation load sets `mode_ready` and sets `lat_half` to 1 for 2.5 clocks or 0 for 2 clocks. Both outputs are visible in the cycle after that edge. Issuing a DLL-reset load clears `mode_ready`.
- R9: With latency 2, a READ sampled on edge n raises both `dv_rise` and `dv_fall` in the cycles beginning at edges n+2 through n+1+BL/2.
- R10: With latency 2.5, a READ sampled on edge n raises `dv_fall` in the cycles beginning at edges n+2 through n+1+BL/2, and `dv_rise` in the cycles beginning at edges n+3 through n+2+BL/2. `dv_fall` marks a beat on the falling edge inside its cycle.
- R11: Several READs in flight are tracked independently. Each output is the OR of the windows of all reads in flight.
- R12: A READ strobe sampled while `mode_ready` is low is ignored and produces no window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Mode-set request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_hi | input | 6 | Requested upper pattern, address bits 12:7 (bit 0 is address bit 7) |
| req_cl | input | 3 | Requested latency code |
| req_bt | input | 1 | Requested burst type |
| req_bl | input | 3 | Requested burst-length code |
| req_err | output | 1 | One-cycle pulse: the accepted request was refused |
| cmd_load | output | 1 | Mode-register load on the bus this cycle (low means NOP) |
| cmd_addr | output | 13 | Address bus value for the load, zero on NOP |
| rd_cmd | input | 1 | READ command issued this cycle |
| mode_ready | output | 1 | A normal-operation load is in force |
| lat_half | output | 1 | Programmed latency is 2.5 clocks |
| dv_rise | output | 1 | A read beat is due on the rising edge that starts this cycle |
| dv_fall | output | 1 | A read beat is due on the falling edge inside this cycle |

## Verification
The checks on the read window assume that the latency and burst length do not change while reads are in flight. They also assume that no DLL-reset load is issued while a window is still open, because `dv_rise` and `dv_fall` are meant to coincide at latency 2 and to fall quiet once `mode_ready` drops. The stimulus respects this by starting each read pattern only after reprogramming has finished, and by running enough idle cycles after every pattern for the tracker to drain. The request channel is driven as a proper valid/ready source: the fields stay constant until acceptance, and `rd_cmd` is held low while a load sequence is running.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  localparam int MR_ADDR_W = 13;
  localparam int MR_HI_W   = 6;
  localparam int BCLK_W    = 3;

  localparam logic [MR_HI_W-1:0] HI_NORMAL    = 6'b000000;
  localparam logic [MR_HI_W-1:0] HI_DLL_RESET = 6'b000010;

  localparam logic [2:0] CL_CODE_2  = 3'b010;
  localparam logic [2:0] CL_CODE_25 = 3'b110;

  localparam logic [2:0] BL_CODE_2 = 3'b001;
  localparam logic [2:0] BL_CODE_4 = 3'b010;
  localparam logic [2:0] BL_CODE_8 = 3'b011;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_GAP = 1'b1} seq_state_t;

  function automatic logic [MR_ADDR_W-1:0] pack_mr(
      input logic [MR_HI_W-1:0] hi, input logic [2:0] cl,
      input logic bt, input logic [2:0] bl);
    return {hi, cl, bt, bl};
  endfunction
endpackage

// File: rtl/mrs_field_check.sv
module mrs_field_check
  import ddr_mrs_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int CL2_MAX_MHZ = 100,
  parameter int MAX_BURST   = 8
) (
  input  logic [MR_HI_W-1:0] hi,
  input  logic [2:0]         cl,
  input  logic [2:0]         bl,
  output logic               ok,
  output logic               is_dll,
  output logic               half,
  output logic [BCLK_W-1:0]  bclks
);
  localparam bit CL2_ALLOWED = (CLK_MHZ <= CL2_MAX_MHZ);
  localparam bit BL8_ALLOWED = (MAX_BURST >= 8);

  logic hi_ok, cl_ok, bl_ok;

  always_comb begin
    is_dll = (hi == HI_DLL_RESET);
    hi_ok  = (hi == HI_NORMAL) || is_dll;

    half  = 1'b0;
    cl_ok = 1'b0;
    unique case (cl)
      CL_CODE_2:  cl_ok = CL2_ALLOWED;
      CL_CODE_25: begin cl_ok = 1'b1; half = 1'b1; end
      default:    cl_ok = 1'b0;
    endcase

    bclks = '0;
    bl_ok = 1'b0;
    unique case (bl)
      BL_CODE_2: begin bl_ok = 1'b1; bclks = BCLK_W'(1); end
      BL_CODE_4: begin bl_ok = 1'b1; bclks = BCLK_W'(2); end
      BL_CODE_8: begin bl_ok = BL8_ALLOWED; bclks = BCLK_W'(4); end
      default:   bl_ok = 1'b0;
    endcase

    ok = hi_ok && cl_ok && bl_ok;
  end
endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
  import ddr_mrs_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [MR_HI_W-1:0]   req_hi,
  input  logic [2:0]           req_cl,
  input  logic                 req_bt,
  input  logic [2:0]           req_bl,
  input  logic                 chk_ok,
  input  logic                 chk_dll,
  input  logic                 chk_half,
  input  logic [BCLK_W-1:0]    chk_bclks,
  output logic                 req_err,
  output logic                 cmd_load,
  output logic [MR_ADDR_W-1:0] cmd_addr,
  output logic                 mode_ready,
  output logic                 lat_half,
  output logic [BCLK_W-1:0]    burst_clks
);
  localparam int GCW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

  seq_state_t        state;
  logic [GCW-1:0]    cnt;
  logic              pend;
  logic [2:0]        sv_cl;
  logic              sv_bt;
  logic [2:0]        sv_bl;
  logic              sv_half;
  logic [BCLK_W-1:0] sv_bclks;
  logic              gap_done;
  logic              accept;

  assign gap_done  = (state == SQ_GAP) && (cnt == '0);
  assign req_ready = (state == SQ_IDLE) || (gap_done && !pend);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      pend       <= 1'b0;
      sv_cl      <= '0;
      sv_bt      <= 1'b0;
      sv_bl      <= '0;
      sv_half    <= 1'b0;
      sv_bclks   <= '0;
      req_err    <= 1'b0;
      cmd_load   <= 1'b0;
      cmd_addr   <= '0;
      mode_ready <= 1'b0;
      lat_half   <= 1'b0;
      burst_clks <= '0;
    end else begin
      cmd_load <= 1'b0;
      cmd_addr <= '0;
      req_err  <= 1'b0;
      if (state == SQ_GAP && cnt != '0) cnt <= cnt - 1'b1;

      if (gap_done && pend) begin
        // follow-up normal-operation load after a DLL reset
        cmd_load   <= 1'b1;
        cmd_addr   <= pack_mr(HI_NORMAL, sv_cl, sv_bt, sv_bl);
        cnt        <= GCW'(GAP_CYC);
        pend       <= 1'b0;
        mode_ready <= 1'b1;
        lat_half   <= sv_half;
        burst_clks <= sv_bclks;
      end else if (accept) begin
        if (!chk_ok) begin
          req_err <= 1'b1;
          state   <= SQ_IDLE;
        end else begin
          cmd_load <= 1'b1;
          cmd_addr <= pack_mr(req_hi, req_cl, req_bt, req_bl);
          state    <= SQ_GAP;
          cnt      <= GCW'(GAP_CYC);
          if (chk_dll) begin
            pend       <= 1'b1;
            sv_cl      <= req_cl;
            sv_bt      <= req_bt;
            sv_bl      <= req_bl;
            sv_half    <= chk_half;
            sv_bclks   <= chk_bclks;
            mode_ready <= 1'b0;
          end else begin
            mode_ready <= 1'b1;
            lat_half   <= chk_half;
            burst_clks <= chk_bclks;
          end
        end
      end else if (gap_done) begin
        state <= SQ_IDLE;
      end
    end
  end

  // bus observer: a DLL-reset load seen on the bus and not yet answered
  logic dll_open;
  always_ff @(posedge clk) begin
    if (!rst_n) dll_open <= 1'b0;
    else if (cmd_load) dll_open <= cmd_addr[8];
  end

  a_r2_legal_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> (cmd_addr[12:9] == 4'b0 && !cmd_addr[7]));

  a_r3_dll_then_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_open && cmd_load) |-> !cmd_addr[8]);

  a_r3_no_accept_open: assert property (@(posedge clk) disable iff (!rst_n)
    dll_open |-> !req_ready);

  a_r4_err_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !cmd_load);

  a_r5_nop_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> (!cmd_load && cmd_addr == '0) ##1 (!cmd_load && cmd_addr == '0));

  a_r8_ready_after_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_addr[8]) |=> mode_ready);
endmodule

// File: rtl/rd_window_tracker.sv
module rd_window_tracker
  import ddr_mrs_pkg::*;
#(
  parameter int MAX_BURST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              mode_ready,
  input  logic              lat_half,
  input  logic [BCLK_W-1:0] burst_clks,
  output logic              dv_rise,
  output logic              dv_fall
);
  localparam int W_MAX = MAX_BURST / 2;
  localparam int DEPTH = 3 + W_MAX;
  localparam int L_FALL = 2;

  // hist[j] holds the READ strobe sampled j edges ago
  logic [DEPTH-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n)          hist <= '0;
    else if (!mode_ready) hist <= '0;
    else                 hist <= {hist[DEPTH-2:0], rd_cmd};
  end

  int l_rise;
  int w;
  always_comb begin
    l_rise  = lat_half ? 3 : 2;
    w       = int'(burst_clks);
    dv_rise = 1'b0;
    dv_fall = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (hist[j] && j >= L_FALL && j < L_FALL + w) dv_fall = 1'b1;
      if (hist[j] && j >= l_rise && j < l_rise + w) dv_rise = 1'b1;
    end
  end

  a_r9_cl2_edges_match: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_half |-> (dv_rise == dv_fall));

  a_r12_quiet_unprogrammed: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ready |=> (!dv_rise && !dv_fall));
endmodule

// File: rtl/ddr_mrs_rdlat.sv
module ddr_mrs_rdlat
  import ddr_mrs_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int CL2_MAX_MHZ = 100,
  parameter int GAP_CYC     = 2,
  parameter int MAX_BURST   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_hi,
  input  logic [2:0]  req_cl,
  input  logic        req_bt,
  input  logic [2:0]  req_bl,
  output logic        req_err,
  output logic        cmd_load,
  output logic [12:0] cmd_addr,
  input  logic        rd_cmd,
  output logic        mode_ready,
  output logic        lat_half,
  output logic        dv_rise,
  output logic        dv_fall
);
  logic              c_ok, c_dll, c_half;
  logic [BCLK_W-1:0] c_bclks;
  logic [BCLK_W-1:0] burst_clks;

  mrs_field_check #(
    .CLK_MHZ(CLK_MHZ), .CL2_MAX_MHZ(CL2_MAX_MHZ), .MAX_BURST(MAX_BURST)
  ) u_check (
    .hi(req_hi), .cl(req_cl), .bl(req_bl),
    .ok(c_ok), .is_dll(c_dll), .half(c_half), .bclks(c_bclks)
  );

  mrs_sequencer #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_hi(req_hi), .req_cl(req_cl), .req_bt(req_bt), .req_bl(req_bl),
    .chk_ok(c_ok), .chk_dll(c_dll), .chk_half(c_half), .chk_bclks(c_bclks),
    .req_err(req_err), .cmd_load(cmd_load), .cmd_addr(cmd_addr),
    .mode_ready(mode_ready), .lat_half(lat_half), .burst_clks(burst_clks)
  );

  rd_window_tracker #(.MAX_BURST(MAX_BURST)) u_trk (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd),
    .mode_ready(mode_ready), .lat_half(lat_half), .burst_clks(burst_clks),
    .dv_rise(dv_rise), .dv_fall(dv_fall)
  );
endmodule

// File: tb/ddr_mrs_rdlat_bench.sv
module ddr_mrs_rdlat_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_bt = 1'b0, rd_cmd = 1'b0;
  logic [5:0]  req_hi = '0;
  logic [2:0]  req_cl = '0, req_bl = '0;
  logic        req_ready, req_err, cmd_load, mode_ready, lat_half, dv_rise, dv_fall;
  logic [12:0] cmd_addr;

  logic        f_valid = 1'b0;
  logic [2:0]  f_cl = 3'b010;
  logic        f_ready, f_err, f_load, f_mr, f_lh, f_dr, f_df;
  logic [12:0] f_addr;

  int checks = 0;
  int errors = 0;

  ddr_mrs_rdlat u_ddr_mrs_rdlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hi(req_hi), .req_cl(req_cl), .req_bt(req_bt), .req_bl(req_bl),
    .req_err(req_err), .cmd_load(cmd_load), .cmd_addr(cmd_addr), .rd_cmd(rd_cmd),
    .mode_ready(mode_ready), .lat_half(lat_half), .dv_rise(dv_rise), .dv_fall(dv_fall)
  );

  ddr_mrs_rdlat #(.CLK_MHZ(133)) u_ddr_mrs_rdlat_fast (
    .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_ready(f_ready),
    .req_hi(6'b0), .req_cl(f_cl), .req_bt(1'b0), .req_bl(3'b010),
    .req_err(f_err), .cmd_load(f_load), .cmd_addr(f_addr), .rd_cmd(1'b0),
    .mode_ready(f_mr), .lat_half(f_lh), .dv_rise(f_dr), .dv_fall(f_df)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [5:0] hi, input logic [2:0] cl, input logic bt,
                        input logic [2:0] bl, input string rq);
    bit ok, dll, half;
    logic pm, ph;
    dll  = (hi == 6'b000010);
    ok   = (hi == 6'b0 || dll) && (cl == 3'b010 || cl == 3'b110) && (bl >= 3'd1 && bl <= 3'd3);
    half = (cl == 3'b110);
    pm = mode_ready; ph = lat_half;
    req_hi = hi; req_cl = cl; req_bt = bt; req_bl = bl; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      chk(rq, "refused req_err", int'(req_err), 1);
      chk("R4", "no load", int'(cmd_load), 0);
      chk("R4", "mode_ready kept", int'(mode_ready), int'(pm));
      chk("R4", "lat_half kept", int'(lat_half), int'(ph));
      @(negedge clk);
      chk("R4", "err one cycle", int'(req_err), 0);
    end else begin
      chk("R1", "load", int'(cmd_load), 1);
      chk("R1", "addr", int'(cmd_addr), int'({hi, cl, bt, bl}));
      chk(rq, "accepted no err", int'(req_err), 0);
      @(negedge clk);
      chk("R5", "nop1 load", int'(cmd_load), 0);
      chk("R5", "nop1 addr", int'(cmd_addr), 0);
      chk("R5", "ready low", int'(req_ready), 0);
      if (dll) chk("R8", "dll clears ready", int'(mode_ready), 0);
      @(negedge clk);
      chk("R5", "nop2 load", int'(cmd_load), 0);
      chk("R5", "nop2 addr", int'(cmd_addr), 0);
      if (dll) begin
        chk("R3", "no accept in sequence", int'(req_ready), 0);
        @(negedge clk);
        chk("R3", "follow-up load", int'(cmd_load), 1);
        chk("R3", "follow-up addr", int'(cmd_addr), int'({6'b0, cl, bt, bl}));
        @(negedge clk);
        chk("R5", "nop after follow-up", int'(cmd_load), 0);
        @(negedge clk);
        chk("R5", "nop2 after follow-up", int'(cmd_load), 0);
      end
      chk("R8", "mode_ready", int'(mode_ready), 1);
      chk("R8", "lat_half", int'(lat_half), int'(half));
      chk("R5", "ready after gap", int'(req_ready), 1);
    end
  endtask

  task automatic run_reads(input logic [5:0] p, input bit half, input int w, input bit live);
    int lr;
    lr = half ? 3 : 2;
    for (int t = 0; t < 18; t++) begin
      bit er, ef;
      er = 1'b0; ef = 1'b0;
      for (int j = 0; j < 6; j++) begin
        int d;
        d = t - 1 - j;
        if (p[j] && live && d >= lr && d < lr + w) er = 1'b1;
        if (p[j] && live && d >= 2 && d < 2 + w) ef = 1'b1;
      end
      if (!live) begin
        chk("R12", "ignored rise", int'(dv_rise), 0);
        chk("R12", "ignored fall", int'(dv_fall), 0);
      end else if (half) begin
        chk("R10", "rise window", int'(dv_rise), int'(er));
        chk("R10", "fall window", int'(dv_fall), int'(ef));
      end else begin
        chk("R9", "rise window", int'(dv_rise), int'(er));
        chk("R9", "fall window", int'(dv_fall), int'(ef));
      end
      if ($countones(p) > 1) chk("R11", "merged rise", int'(dv_rise), int'(er));
      rd_cmd = (t < 6) ? p[t] : 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "reset load", int'(cmd_load), 0);
    chk("R5", "reset addr", int'(cmd_addr), 0);
    chk("R8", "reset mode_ready", int'(mode_ready), 0);
    chk("R4", "reset err", int'(req_err), 0);
    chk("R5", "reset ready", int'(req_ready), 1);

    // CL2 above its frequency limit is refused by the 133 MHz configuration
    f_valid = 1'b1; f_cl = 3'b010;
    @(negedge clk);
    chk("R6", "fast cl2 refused", int'(f_err), 1);
    chk("R6", "fast cl2 no load", int'(f_load), 0);
    f_cl = 3'b110;
    @(negedge clk);
    f_valid = 1'b0;
    chk("R6", "fast cl2.5 load", int'(f_load), 1);
    chk("R6", "fast cl2.5 addr", int'(f_addr), int'({6'b0, 3'b110, 1'b0, 3'b010}));

    // reads before any programming are ignored
    run_reads(6'b010101, 1'b0, 2, 1'b0);

    do_req(6'b0, 3'b010, 1'b0, 3'b010, "R1");

    for (int h = 0; h < 64; h++) do_req(6'(h), 3'b110, 1'b1, 3'b010, "R2");
    for (int c = 0; c < 8; c++) do_req(6'b0, 3'(c), 1'b0, 3'b001, "R6");
    for (int b = 0; b < 8; b++) do_req(6'b000010, 3'b010, 1'b0, 3'(b), "R7");

    for (int c = 0; c < 2; c++) begin
      for (int b = 1; b <= 3; b++) begin
        logic [2:0] clc;
        int w;
        clc = (c == 0) ? 3'b010 : 3'b110;
        w = (b == 1) ? 1 : ((b == 2) ? 2 : 4);
        do_req(6'b000010, clc, 1'(b & 1), 3'(b), "R3");
        for (int p = 0; p < 64; p++) run_reads(6'(p), (c == 1), w, 1'b1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule